// File: doc/BRIEF.md
# Up-Counting Event Timer with Update Interrupt

This block is a general-purpose up-counting timer controlled over a plain 32-bit register bus with address, write strobe, write data and registered read data. A programmable prescaler divides the input clock. The counter climbs from zero to an auto-reload limit, wraps, and raises an update flag that can drive a level interrupt. It runs either periodically or as a single shot that stops itself. Software can also force an update event.

Both the prescaler and the reload value are buffered. A new prescaler value always waits for the next update event. A new reload value waits too when preload is enabled; otherwise it applies at once. The reload register keeps only the implemented counter width. Software finds out whether the counter has 16 or 32 bits by writing all ones to the reload register and reading it back.

Top module: `evt_timer`

## Requirements
- R1: After reset, every readable register (control 0x00, interrupt enable 0x0C, status 0x10, prescaler 0x28, reload 0x2C) reads 0 and `irq_o` is low. Unmapped offsets and the event register at 0x14 read 0. Read data appears one clock after the address is presented.
- R2: Control bits are: bit 0 run, bit 3 single-shot, bit 7 reload preload. While bit 0 is low the counter holds its value. Writing 0 to control stops the timer, and no update follows.
- R3: With prescaler value P and active reload value A, the first update after the run bit is written comes (A+1)*(P+1) clocks after that write's clock edge. In periodic mode each later update follows the previous one by the same interval.
- R4: The reload register keeps only CNT_W bits. Reads return the last written value, zero-extended. With CNT_W=16, writing 0xFFFFFFFF reads back 0x0000FFFF.
- R5: Writing 1 to bit 0 of the event register at 0x14 forces an update event. The event clears the counter and the prescaler phase, loads the buffered prescaler and reload values, and sets the status flag.
- R6: With preload on, a reload write is held in a buffer and becomes active only at the next update. With preload off, it becomes active at once.
- R7: A prescaler write takes effect only at the next update event.
- R8: In single-shot mode the update clears control bit 0, so control reads back with bit 0 low and bit 3 still set. No further update occurs.
- R9: Status bit 0 is set by every update event, whatever the interrupt enable. Writing a 0 to that bit clears it; writing a 1 leaves it unchanged. `irq_o` is high exactly while that flag and interrupt-enable bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Level update interrupt |

## Verification
The bench checks the update period for several prescaler and reload pairs. A design off by one in either divider would fire one tick or one clock early or late. It writes a new reload value while the counter is running, both with and without preload. A design that ignores the preload bit would stretch the first period in the buffered case, or fail to stretch it in the direct case. It also writes a prescaler value without forcing an update and expects the old division to hold for one more period; applying the value at once would scale that period five-fold. Finally it checks that a single shot clears the run bit, that writing 1 to the status register leaves the flag set, and that a disabled interrupt hides the flag from `irq_o` but not from the status read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_IEN  = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_EVT  = 8'h14;
  localparam logic [7:0] OFF_DIV  = 8'h28;
  localparam logic [7:0] OFF_TOP  = 8'h2C;
  // control bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_ONE  = 3;
  localparam int CTL_PRE  = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             reload,
  input  logic [PSC_W-1:0] div_next,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;
  logic [PSC_W-1:0] div_act;

  assign tick = run && (phase_q == div_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      div_act <= '0;
    end else if (reload) begin
      phase_q <= '0;
      div_act <= div_next;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

  // R7
  psc_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q <= div_act);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             pre_en,
  input  logic             top_we,
  input  logic [CNT_W-1:0] top_wd,
  output logic             upd,
  output logic [CNT_W-1:0] top_buf
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_act;
  logic             wrap;

  assign wrap = tick && (cnt_q == top_act);
  assign upd  = force_upd || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      top_act <= '0;
      top_buf <= '0;
    end else begin
      if (top_we) top_buf <= top_wd;
      if (upd) begin
        cnt_q   <= '0;
        top_act <= top_buf;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (top_we && !pre_en) top_act <= top_wd;
    end
  end

  // R5
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cnt_q == '0));
  // R6
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_en && !upd) |=> $stable(top_act));
  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !force_upd) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  import tmr_pkg::*;

  logic run_q, one_q, pre_q, ien_q, flag_q;
  logic [PSC_W-1:0] div_buf;
  logic [CNT_W-1:0] top_buf;
  logic wr_ctrl, wr_ien, wr_stat, wr_evt, wr_div, wr_top;
  logic force_upd, upd, tick;
  logic unused_wbits;

  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign wr_ien  = bus_we && (bus_addr == OFF_IEN);
  assign wr_stat = bus_we && (bus_addr == OFF_STAT);
  assign wr_evt  = bus_we && (bus_addr == OFF_EVT);
  assign wr_div  = bus_we && (bus_addr == OFF_DIV);
  assign wr_top  = bus_we && (bus_addr == OFF_TOP);
  assign force_upd = wr_evt && bus_wdata[0];
  assign unused_wbits = ^bus_wdata;

  tmr_prescale #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .reload(upd),
    .div_next(div_buf), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .force_upd(force_upd),
    .pre_en(pre_q), .top_we(wr_top), .top_wd(bus_wdata[CNT_W-1:0]),
    .upd(upd), .top_buf(top_buf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      one_q   <= 1'b0;
      pre_q   <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      div_buf <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTL_RUN];
        one_q <= bus_wdata[CTL_ONE];
        pre_q <= bus_wdata[CTL_PRE];
      end else if (upd && one_q) begin
        run_q <= 1'b0;
      end
      if (wr_ien) ien_q <= bus_wdata[0];
      if (upd) flag_q <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
      if (wr_div) div_buf <= bus_wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFF_CTRL: begin
          bus_rdata          <= '0;
          bus_rdata[CTL_RUN] <= run_q;
          bus_rdata[CTL_ONE] <= one_q;
          bus_rdata[CTL_PRE] <= pre_q;
        end
        OFF_IEN:  bus_rdata <= {31'd0, ien_q};
        OFF_STAT: bus_rdata <= {31'd0, flag_q};
        OFF_DIV:  bus_rdata <= 32'(div_buf);
        OFF_TOP:  bus_rdata <= 32'(top_buf);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_o = flag_q & ien_q;

  // R9
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(upd));
  // R8
  one_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && one_q && !wr_ctrl) |=> !run_q);
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !bus_wdata[0] && !upd) |=> !irq_o);
endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam int CNT_W = 16;
  localparam logic [31:0] TOP_MASK = (32'd1 << CNT_W) - 1;
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                         A_EVT = 8'h14, A_DIV = 8'h28, A_TOP = 8'h2C;
  // {prescaler, reload, expected clocks to update}
  localparam logic [47:0] VEC [6] = '{
    {16'd0, 16'd0, 16'd1},
    {16'd0, 16'd1, 16'd2},
    {16'd0, 16'd5, 16'd6},
    {16'd1, 16'd3, 16'd8},
    {16'd2, 16'd4, 16'd15},
    {16'd3, 16'd0, 16'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_timer #(.CNT_W(CNT_W), .PSC_W(16)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic measure(input int start, output int n);
    n = start;
    while (!irq_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic prime(input logic [31:0] div, input logic [31:0] top);
    wr(A_CTRL, 32'h0);
    wr(A_DIV, div);
    wr(A_TOP, top);
    wr(A_EVT, 32'h1);
    wr(A_STAT, 32'h0);
  endtask

  task automatic finish_all();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_all();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_IEN, v);  chk("R1 ien", v, 32'h0);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);
    rd(A_DIV, v);  chk("R1 div", v, 32'h0);
    rd(A_TOP, v);  chk("R1 top", v, 32'h0);
    rd(A_EVT, v);  chk("R1 evt", v, 32'h0);

    // R4 width discovery
    wr(A_TOP, 32'hFFFF_FFFF);
    rd(A_TOP, v); chk("R4 top width", v, TOP_MASK);
    wr(A_TOP, 32'h0001_2345);
    rd(A_TOP, v); chk("R4 top trunc", v, 32'h0001_2345 & TOP_MASK);

    wr(A_IEN, 32'h1);

    // R3 R8 vector walk in single-shot mode
    for (int i = 0; i < 6; i++) begin
      logic [15:0] p, a, e;
      p = VEC[i][47:32]; a = VEC[i][31:16]; e = VEC[i][15:0];
      wr(A_CTRL, 32'h0);
      wr(A_DIV, {16'd0, p});
      wr(A_TOP, {16'd0, a});
      wr(A_EVT, 32'h1);
      chk("R5 forced update sets flag", {31'd0, irq_o}, 32'h1);
      wr(A_STAT, 32'h0);
      chk("R9 clear flag", {31'd0, irq_o}, 32'h0);
      wr(A_CTRL, 32'h09);
      measure(0, n);
      chk("R3 period", n, {16'd0, e});
      rd(A_CTRL, v); chk("R8 run cleared", v, 32'h08);
      wr(A_STAT, 32'h0);
      repeat (3 * e + 5) @(negedge clk);
      chk("R8 no second update", {31'd0, irq_o}, 32'h0);
    end

    // R9 writing 1 to status keeps flag
    wr(A_EVT, 32'h1);
    wr(A_STAT, 32'h1);
    chk("R9 write1 keeps irq", {31'd0, irq_o}, 32'h1);
    rd(A_STAT, v); chk("R9 stat set", v, 32'h1);
    wr(A_STAT, 32'h0);
    chk("R9 write0 clears", {31'd0, irq_o}, 32'h0);

    // R9 interrupt enable gating
    wr(A_IEN, 32'h0);
    wr(A_EVT, 32'h1);
    chk("R9 gated irq", {31'd0, irq_o}, 32'h0);
    rd(A_STAT, v); chk("R9 flag without enable", v, 32'h1);
    wr(A_IEN, 32'h1);
    chk("R9 irq after enable", {31'd0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0);

    // R7 prescaler waits for update
    prime(32'd0, 32'd1);
    wr(A_DIV, 32'd4);
    wr(A_CTRL, 32'h09);
    measure(0, n); chk("R7 old divider kept", n, 32'd2);
    wr(A_STAT, 32'h0);
    wr(A_CTRL, 32'h09);
    measure(0, n); chk("R7 new divider after update", n, 32'd10);
    wr(A_STAT, 32'h0);

    // R6 preload on: reload write waits, periodic continues
    prime(32'd0, 32'd3);
    wr(A_CTRL, 32'h81);
    wr(A_TOP, 32'd9);
    measure(2, n); chk("R6 buffered first period", n, 32'd4);
    wr(A_STAT, 32'h0);
    measure(6, n); chk("R6 R3 second period uses new top", n, 32'd14);

    // R6 preload off: immediate
    prime(32'd0, 32'd3);
    wr(A_CTRL, 32'h01);
    wr(A_TOP, 32'd9);
    measure(2, n); chk("R6 direct top", n, 32'd10);

    // R2 stop by writing 0
    prime(32'd0, 32'd9);
    wr(A_CTRL, 32'h01);
    wr(A_CTRL, 32'h00);
    repeat (40) @(negedge clk);
    chk("R2 stopped no update", {31'd0, irq_o}, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl zero", v, 32'h0);

    finish_all();
  end
endmodule